// File: doc/BRIEF.md
# Binary32 Multiplier with Status Flags

This block multiplies two IEEE-754 single-precision operands and reports four status flags with each product: overflow, underflow, inexact and invalid. It is meant for datapaths that need a product every cycle and can accept a simplified number model. Operands whose exponent field is zero (zero or subnormal) are taken as zero. Any result too small to be a normal number is flushed to a signed zero. Rounding is always round-to-nearest-even.

An operand pair is accepted with a valid strobe on any cycle. After a fixed number of register stages, set at build time to 0, 1, 2 or 3, the result, the flags and the valid strobe appear together. No handshake or stall exists: one product can enter per cycle.

Top module: `sp_mul_flags`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly LATENCY clock cycles (0 to 3). Result and flags travel with it.
- R2: For two normal operands whose product is in range, `result` is the correctly rounded (nearest, ties to even) binary32 product. The sign is bit 31, the biased exponent is bits 30:23 and the fraction is bits 22:0.
- R3: If the rounded biased exponent reaches 255, `result` is infinity of the product's sign (exponent 0xFF, fraction 0). `flag_overflow` and `flag_inexact` are both 1.
- R4: If the rounded biased exponent is below 1, `result` is zero of the product's sign. `flag_underflow` and `flag_inexact` are both 1.
- R5: For an in-range product, `flag_inexact` is 1 exactly when a non-zero product bit was discarded. This includes an exact tie that rounds to even.
- R6: Infinity times a zero or a subnormal, in either operand order, gives 0x7FC00000 with only `flag_invalid` set.
- R7: Any NaN operand (exponent 0xFF, fraction non-zero) gives 0x7FC00000 with all flags clear, whatever the other operand is.
- R8: An operand with exponent field 0 and a non-zero fraction behaves exactly like zero of the same sign.
- R9: Infinity times a normal number or infinity gives infinity with all flags clear.
- R10: The result sign is the XOR of the operand signs for zero, infinity and finite results alike. The only exception is the generated NaN, whose sign is 0.
- R11: While `rst_n` is low and after it is released, the output stages read zero: `out_valid` = 0, `result` = 0 and all flags are 0 until data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result valid, LATENCY cycles after `in_valid` |
| result | output | 32 | Binary32 product |
| flag_overflow | output | 1 | Product exceeded the largest finite value |
| flag_underflow | output | 1 | Product fell below the smallest normal value and was flushed |
| flag_inexact | output | 1 | Result differs from the exact product |
| flag_invalid | output | 1 | Infinity multiplied by zero |

## Verification
Rounding and range limiting can act on the same product. A rounding carry can lift the exponent from 254 to 255 and turn a finite value into an overflow. It can also decide whether a product near the smallest normal value is kept or flushed. This is provoked with directed operands just below the largest finite value, and with a sweep over boundary exponents combined with all-ones, tie and sparse fractions. Each output is compared with an integer model that finds the leading one, rounds, and only then tests the exponent range. The checks look at the result and all four flags of that same output cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fpm_cls_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
    logic inv;
  } fpm_flags_t;

  typedef struct packed {
    logic [22:0] mant;
    logic [1:0]  eadj;
    logic        inexact;
  } fpm_rnd_t;

  localparam logic [31:0] FPM_QNAN = 32'h7FC0_0000;

  function automatic fpm_cls_e fpm_classify(input logic [7:0] e, input logic [22:0] f);
    if (e == 8'd0)        return CLS_ZERO;
    else if (e != 8'hFF)  return CLS_NORM;
    else if (f == 23'd0)  return CLS_INF;
    else                  return CLS_NAN;
  endfunction

  // Normalise a 48-bit significand product and round to nearest even.
  function automatic fpm_rnd_t fpm_round(input logic [47:0] p);
    fpm_rnd_t    r;
    logic        hi, g, s, up, cy;
    logic [22:0] m;
    hi = p[47];
    m  = hi ? p[46:24] : p[45:23];
    g  = hi ? p[23]    : p[22];
    s  = hi ? (|p[22:0]) : (|p[21:0]);
    up = g & (s | m[0]);
    {cy, r.mant} = {1'b0, m} + {23'd0, up};
    r.eadj    = {1'b0, hi} + {1'b0, cy};
    r.inexact = g | s;
    return r;
  endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [31:0] word,
  output logic        sign,
  output logic [7:0]  expo,
  output logic [22:0] frac,
  output fpm_cls_e    cls
);
  assign sign = word[31];
  assign expo = word[30:23];
  assign frac = word[22:0];
  assign cls  = fpm_classify(word[30:23], word[22:0]);
endmodule

// File: rtl/fpm_core.sv
module fpm_core
  import fpm_pkg::*;
(
  input  fpm_cls_e    cls_a,
  input  fpm_cls_e    cls_b,
  input  logic        sign,
  input  logic [7:0]  ea,
  input  logic [7:0]  eb,
  input  logic [22:0] fa,
  input  logic [22:0] fb,
  output logic [31:0] res,
  output fpm_flags_t  flags
);
  logic [47:0] prod;
  fpm_rnd_t    rr;
  logic signed [9:0] e_sum;

  assign prod  = 48'({1'b1, fa}) * 48'({1'b1, fb});
  assign rr    = fpm_round(prod);
  assign e_sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - 10'sd127
               + $signed({8'd0, rr.eadj});

  always_comb begin
    res   = {sign, 31'd0};
    flags = '0;
    if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
      res = FPM_QNAN;
    end else if ((cls_a == CLS_INF && cls_b == CLS_ZERO) ||
                 (cls_a == CLS_ZERO && cls_b == CLS_INF)) begin
      res       = FPM_QNAN;
      flags.inv = 1'b1;
    end else if (cls_a == CLS_INF || cls_b == CLS_INF) begin
      res = {sign, 8'hFF, 23'd0};
    end else if (cls_a == CLS_ZERO || cls_b == CLS_ZERO) begin
      res = {sign, 31'd0};
    end else if (e_sum >= 10'sd255) begin
      res       = {sign, 8'hFF, 23'd0};
      flags.ovf = 1'b1;
      flags.inx = 1'b1;
    end else if (e_sum < 10'sd1) begin
      res       = {sign, 31'd0};
      flags.unf = 1'b1;
      flags.inx = 1'b1;
    end else begin
      res       = {sign, e_sum[7:0], rr.mant};
      flags.inx = rr.inexact;
    end
  end
endmodule

// File: rtl/fpm_pipe.sv
module fpm_pipe #(
  parameter int W     = 37,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] st [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) st[i] <= '0;
        end else begin
          st[0] <= d;
          for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
        end
      end
      assign q = st[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sp_mul_flags.sv
module sp_mul_flags
  import fpm_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact,
  output logic        flag_invalid
);
  localparam int STAGES = (LATENCY > 3) ? 3 : ((LATENCY < 0) ? 0 : LATENCY);
  localparam int PW     = 1 + 32 + 4;

  logic        sa, sb;
  logic [7:0]  ea, eb;
  logic [22:0] fa, fb;
  fpm_cls_e    cls_a, cls_b;
  logic [31:0] core_res;
  fpm_flags_t  core_flags;
  logic [PW-1:0] pipe_out;
  fpm_flags_t  out_flags;

  fpm_unpack u_unp_a (.word(op_a), .sign(sa), .expo(ea), .frac(fa), .cls(cls_a));
  fpm_unpack u_unp_b (.word(op_b), .sign(sb), .expo(eb), .frac(fb), .cls(cls_b));

  fpm_core u_core (
    .cls_a(cls_a), .cls_b(cls_b), .sign(sa ^ sb),
    .ea(ea), .eb(eb), .fa(fa), .fb(fb),
    .res(core_res), .flags(core_flags)
  );

  fpm_pipe #(.W(PW), .DEPTH(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .d({in_valid, core_res, core_flags}),
    .q(pipe_out)
  );

  assign out_valid      = pipe_out[PW-1];
  assign result         = pipe_out[PW-2:4];
  assign out_flags      = pipe_out[3:0];
  assign flag_overflow  = out_flags.ovf;
  assign flag_underflow = out_flags.unf;
  assign flag_inexact   = out_flags.inx;
  assign flag_invalid   = out_flags.inv;
endmodule

// File: rtl/sp_mul_flags_chk.sv
module sp_mul_flags_chk #(
  parameter int LATENCY = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact,
  input logic        flag_invalid
);
  generate
    if (LATENCY > 0 && LATENCY <= 3) begin : g_lat
      logic [1:0] since_rst;
      always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'(LATENCY)) since_rst <= since_rst + 2'd1;
      end
      p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));
    end
  endgenerate

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> (result[30:0] == 31'h7F80_0000 && !flag_underflow));
  p_flush_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (result[30:0] == 31'd0));
  p_range_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overflow || flag_underflow) |-> flag_inexact);
  p_invalid_qnan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (result == 32'h7FC0_0000 &&
                      $countones({flag_overflow, flag_underflow, flag_inexact}) == 0));
  p_nan_only_qnan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result[30:23] == 8'hFF && result[22:0] != 23'd0) |-> (result == 32'h7FC0_0000));
endmodule

bind sp_mul_flags sp_mul_flags_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
  .flag_inexact(flag_inexact), .flag_invalid(flag_invalid)
);

// File: tb/sim_sp_mul_flags.sv
module sim_sp_mul_flags;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        f_ovf, f_unf, f_inx, f_inv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sp_mul_flags #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .flag_overflow(f_ovf),
    .flag_underflow(f_unf), .flag_inexact(f_inx), .flag_invalid(f_inv)
  );

  always #10 clk = ~clk;

  // expected-value shift line, index 0 = most recently driven
  logic        q_v [LAT];
  logic [31:0] q_r [LAT];
  logic [3:0]  q_f [LAT];
  string       q_t [LAT];

  // {ovf,unf,inx,inv, result}
  function automatic logic [35:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic sr;
    int ea, eb, k, sh, e;
    logic [63:0] p, q, rem, half;
    logic up;
    sr = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0))
      return {4'b0000, 32'h7FC0_0000};
    if ((ea == 255 && eb == 0) || (ea == 0 && eb == 255))
      return {4'b0001, 32'h7FC0_0000};
    if (ea == 255 || eb == 255) return {4'b0000, sr, 8'hFF, 23'd0};
    if (ea == 0 || eb == 0)     return {4'b0000, sr, 31'd0};
    p = 64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]});
    k = 47;
    while (p[k] == 1'b0) k--;
    sh   = k - 23;
    q    = p >> sh;
    rem  = p & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    up   = (rem > half) || (rem == half && q[0]);
    q    = q + 64'(up);
    if (q == (64'd1 << 24)) begin q = q >> 1; k++; end
    e = ea + eb - 127 + (k - 46);
    if (e >= 255) return {4'b1010, sr, 8'hFF, 23'd0};
    if (e < 1)    return {4'b0110, sr, 31'd0};
    return {2'b00, (rem != 0), 1'b0, sr, 8'(e), q[22:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] f, input logic [31:0] r);
    if (f[0]) return "R6";
    if (r == 32'h7FC0_0000) return "R7";
    if (f[3]) return "R3";
    if (f[2]) return "R4";
    if (f[1]) return "R5";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual flags=%b result=%h expected flags=%b result=%h",
               tag, act[35:32], act[31:0], expv[35:32], expv[31:0]);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] er, input logic [3:0] ef, input string tag);
    logic [35:0] act;
    @(negedge clk);
    act = {f_ovf, f_unf, f_inx, f_inv, result};
    check(out_valid == q_v[LAT-1], "R1", {35'd0, out_valid}, {35'd0, q_v[LAT-1]});
    if (q_v[LAT-1])
      check(act == {q_f[LAT-1], q_r[LAT-1]}, q_t[LAT-1], act, {q_f[LAT-1], q_r[LAT-1]});
    for (int i = LAT - 1; i > 0; i--) begin
      q_v[i] = q_v[i-1]; q_r[i] = q_r[i-1]; q_f[i] = q_f[i-1]; q_t[i] = q_t[i-1];
    end
    q_v[0] = v; q_r[0] = er; q_f[0] = ef; q_t[0] = tag;
    in_valid = v; op_a = a; op_b = b;
  endtask

  task automatic dir(input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] er, input logic [3:0] ef, input string tag);
    step(1'b1, a, b, er, ef, tag);
  endtask

  function automatic logic [7:0] sw_exp(input int i);
    case (i)
      0: return 8'd0;    1: return 8'd1;    2: return 8'd2;    3: return 8'd63;
      4: return 8'd126;  5: return 8'd127;  6: return 8'd128;  7: return 8'd200;
      8: return 8'd253;  9: return 8'd254;  default: return 8'd255;
    endcase
  endfunction

  function automatic logic [22:0] sw_frac(input int i);
    case (i)
      0: return 23'h000000; 1: return 23'h000001; 2: return 23'h400000;
      3: return 23'h7FFFFF; 4: return 23'h2AAAAA; default: return 23'h000003;
    endcase
  endfunction

  function automatic logic [31:0] sw_val(input int i);
    return {i[0], sw_exp((i >> 1) % 11), sw_frac((i >> 1) / 11)};
  endfunction

  initial begin
    for (int i = 0; i < LAT; i++) begin
      q_v[i] = 1'b0; q_r[i] = '0; q_f[i] = '0; q_t[i] = "R1";
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({out_valid, result, f_ovf, f_unf, f_inx, f_inv} == '0, "R11",
          {f_ovf, f_unf, f_inx, f_inv, result}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_valid, result, f_ovf, f_unf, f_inx, f_inv} == '0, "R11",
          {f_ovf, f_unf, f_inx, f_inv, result}, 36'd0);

    // flags order: {ovf,unf,inx,inv}
    dir(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 4'b0000, "R2");
    dir(32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 4'b0000, "R2");
    dir(32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0002, 4'b0010, "R5");
    dir(32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0002, 4'b0010, "R5");
    step(1'b0, 32'h7F80_0000, 32'h0, 32'h0, 4'b0000, "R1");
    dir(32'h7F00_0000, 32'h7F00_0000, 32'h7F80_0000, 4'b1010, "R3");
    dir(32'h7F7F_FFFF, 32'h3F80_0001, 32'h7F80_0000, 4'b1010, "R3");
    dir(32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 4'b0110, "R4");
    dir(32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 4'b0110, "R4");
    dir(32'h7F80_0000, 32'h0000_0000, 32'h7FC0_0000, 4'b0001, "R6");
    dir(32'h0000_0001, 32'hFF80_0000, 32'h7FC0_0000, 4'b0001, "R6");
    dir(32'h7FC0_0000, 32'h0000_0000, 32'h7FC0_0000, 4'b0000, "R7");
    dir(32'h3F80_0000, 32'hFFA0_0000, 32'h7FC0_0000, 4'b0000, "R7");
    dir(32'h0040_0000, 32'h4000_0000, 32'h0000_0000, 4'b0000, "R8");
    dir(32'h8040_0000, 32'h4000_0000, 32'h8000_0000, 4'b0000, "R8");
    dir(32'hFF80_0000, 32'h4000_0000, 32'hFF80_0000, 4'b0000, "R9");
    dir(32'hFF80_0000, 32'hFF80_0000, 32'h7F80_0000, 4'b0000, "R9");
    dir(32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 4'b0000, "R10");
    dir(32'h0000_0000, 32'hC000_0000, 32'h8000_0000, 4'b0000, "R10");

    // sweep: 132 values per operand, valid dropped on some cycles (R1)
    for (int i = 0; i < 132; i++) begin
      for (int j = 0; j < 132; j++) begin
        logic [35:0] e;
        e = ref_mul(sw_val(i), sw_val(j));
        step(((i * 132 + j) % 7) != 3, sw_val(i), sw_val(j), e[31:0], e[35:32],
             tag_of(e[35:32], e[31:0]));
      end
    end
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, '0, '0, "R1");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule